// File: doc/BRIEF.md
# Hardware Thread Fork Allocator

This block serves a fork request from a running thread context on a small multithreaded core. When the request is accepted, it walks a bank of per-context status bits, one context per clock cycle, in ascending index order. It looks for the first context that is bound to the requester's virtual processor, that may be allocated dynamically, and that is neither halted nor already activated.

When it finds such a context, it issues one set of write strobes into the context register bank. The restart PC of the chosen context gets the first operand. One selected general register of that context gets the second operand. The status word of that context is written with a fresh run state, and it inherits the requester's privilege mode and address-space identifier. If no context qualifies within the configured scan range, the block reports a thread fault and a coded exception value for the virtual-processor control register.

The register bank, the pipeline and instruction decode sit outside this block. The block only reads the per-context eligibility bits and drives write strobes.

Top module: `tfa_fork_alloc`

## Requirements
- R1: After reset, `busy`, `done`, `ok`, `fault`, `pc_we`, `gpr_we`, `st_we` and `exc_we` are all 0. An asserted reset in the middle of a scan returns the block to that idle state.
- R2: Context i is eligible only when all of the following hold: `ctx_vpe[i*VPE_W +: VPE_W]` equals `req_vpe`, `ctx_dyn[i]`=1, `ctx_halt[i]`=0 and `ctx_act[i]`=0.
- R3: The scan examines one context per cycle, starting at index 0 and rising. It selects the lowest-index eligible context. When that context is k, `done` rises exactly k+1 clock edges after the edge that accepts the request.
- R4: The scan covers contexts 0 through `cfg_count`, which is `cfg_count`+1 contexts. An eligible context with an index above `cfg_count` is never selected.
- R5: On success, `pc_we` and `gpr_we` pulse in the same cycle as `done`, and `wr_ctx` equals the selected index. `pc_wdata` equals the captured `req_pc`, `gpr_addr` equals `req_dst` and `gpr_wdata` equals `req_val`.
- R6: On success, `st_we` pulses with the following status fields: `st_run`=0, `st_dly`=0, `st_dirty`=1 and `st_act`=1. `st_ksu` equals the captured `req_ksu` and `st_asid` equals the captured `req_asid`.
- R7: When no context in range is eligible, `done` and `fault` pulse together `cfg_count`+1 edges after acceptance. In that cycle `exc_we`=1 and `exc_code`=3'd1, and none of the write strobes is asserted.
- R8: `busy` is 1 from the edge that accepts a request until the edge at which `done` rises. A `fork_req` seen while `busy` is 1 is ignored and produces no further `done`.
- R9: `done`, `ok` and `fault` are single-cycle pulses. Every `done` comes with exactly one of `ok` or `fault`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fork_req | input | 1 | Fork request, sampled when idle |
| req_vpe | input | VPE_W | Virtual processor of the requester |
| req_ksu | input | 2 | Requester privilege mode |
| req_asid | input | ASID_W | Requester address-space identifier |
| req_pc | input | DATA_W | Restart PC for the new context |
| req_val | input | DATA_W | Register payload for the new context |
| req_dst | input | REG_W | Destination register index |
| cfg_count | input | IDX_W | Highest context index to scan |
| ctx_vpe | input | N_CTX*VPE_W | Per-context virtual processor binding |
| ctx_dyn | input | N_CTX | Per-context dynamic-allocation enable |
| ctx_halt | input | N_CTX | Per-context halt bit |
| ctx_act | input | N_CTX | Per-context activated bit |
| busy | output | 1 | Scan in progress |
| wr_ctx | output | IDX_W | Target context of the write strobes |
| pc_we | output | 1 | Restart PC write strobe |
| pc_wdata | output | DATA_W | Restart PC value |
| gpr_we | output | 1 | Register write strobe |
| gpr_addr | output | REG_W | Register index |
| gpr_wdata | output | DATA_W | Register value |
| st_we | output | 1 | Status word write strobe |
| st_run | output | 2 | Run-state field |
| st_dly | output | 1 | Delay-slot flag |
| st_dirty | output | 1 | Dirty flag |
| st_act | output | 1 | Activated flag |
| st_ksu | output | 2 | Inherited privilege mode |
| st_asid | output | ASID_W | Inherited address-space identifier |
| exc_we | output | 1 | Exception field write strobe |
| exc_code | output | 3 | Exception code value |
| done | output | 1 | Scan finished pulse |
| ok | output | 1 | Fork succeeded |
| fault | output | 1 | Thread fault, no free context |

## Verification
Two events can fall in the same cycle: a fresh `fork_req` and the scan's final step, where the block either commits a context or raises a fault. The bench holds `fork_req` high across the edge at which the scan completes. It then watches the ports for a dozen cycles and requires that no second `done` appears. A second request issued in the middle of a scan, carrying a different PC, is judged the same way, and the bench also checks that the one write that does occur carries the first request's PC.

// File: rtl/tfa_pkg.sv
package tfa_pkg;
    typedef enum logic {
        TFA_IDLE = 1'b0,
        TFA_SCAN = 1'b1
    } tfa_state_e;

    localparam logic [2:0] TFA_EXC_NO_FREE = 3'd1;
endpackage

// File: rtl/tfa_elig.sv
module tfa_elig #(
    parameter int N_CTX = 8,
    parameter int VPE_W = 2
) (
    input  logic [N_CTX*VPE_W-1:0] ctx_vpe,
    input  logic [N_CTX-1:0]       ctx_dyn,
    input  logic [N_CTX-1:0]       ctx_halt,
    input  logic [N_CTX-1:0]       ctx_act,
    input  logic [VPE_W-1:0]       req_vpe,
    output logic [N_CTX-1:0]       elig
);
    // One qualifier per context: same binding, allocatable, not halted, idle.
    for (genvar i = 0; i < N_CTX; i++) begin : g_ctx
        logic same_vpe;
        assign same_vpe = (ctx_vpe[i*VPE_W +: VPE_W] == req_vpe);
        assign elig[i]  = same_vpe & ctx_dyn[i] & ~ctx_halt[i] & ~ctx_act[i];
    end
endmodule

// File: rtl/tfa_seq.sv
module tfa_seq
    import tfa_pkg::*;
#(
    parameter int N_CTX  = 8,
    parameter int IDX_W  = 3,
    parameter int ASID_W = 8,
    parameter int DATA_W = 32,
    parameter int REG_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fork_req,
    input  logic [1:0]        req_ksu,
    input  logic [ASID_W-1:0] req_asid,
    input  logic [DATA_W-1:0] req_pc,
    input  logic [DATA_W-1:0] req_val,
    input  logic [REG_W-1:0]  req_dst,
    input  logic [IDX_W-1:0]  cfg_count,
    input  logic [N_CTX-1:0]  elig,
    output logic              busy,
    output logic [IDX_W-1:0]  wr_ctx,
    output logic              wr_stb,
    output logic [DATA_W-1:0] pc_data,
    output logic [DATA_W-1:0] val_data,
    output logic [REG_W-1:0]  dst_idx,
    output logic              st_dirty,
    output logic              st_act,
    output logic [1:0]        st_ksu,
    output logic [ASID_W-1:0] st_asid,
    output logic              exc_we,
    output logic [2:0]        exc_code,
    output logic              done,
    output logic              ok,
    output logic              fault
);
    localparam logic [IDX_W-1:0] MAX_IDX = IDX_W'(N_CTX - 1);

    typedef struct packed {
        tfa_state_e        st;
        logic [IDX_W-1:0]  idx;
        logic [IDX_W-1:0]  last;
        logic [DATA_W-1:0] pc;
        logic [DATA_W-1:0] val;
        logic [REG_W-1:0]  dst;
        logic [1:0]        ksu;
        logic [ASID_W-1:0] asid;
        logic [IDX_W-1:0]  wctx;
        logic              wr;
        logic              dirty;
        logic              act;
        logic              exc_we;
        logic [2:0]        exc_code;
        logic              done;
        logic              ok;
        logic              fault;
    } tfa_regs_t;

    tfa_regs_t r_d, r_q;
    logic [IDX_W-1:0] last_lim;

    always_comb begin
        last_lim = (cfg_count > MAX_IDX) ? MAX_IDX : cfg_count;
        r_d          = r_q;
        r_d.wr       = 1'b0;
        r_d.dirty    = 1'b0;
        r_d.act      = 1'b0;
        r_d.exc_we   = 1'b0;
        r_d.exc_code = 3'd0;
        r_d.done     = 1'b0;
        r_d.ok       = 1'b0;
        r_d.fault    = 1'b0;
        case (r_q.st)
            TFA_IDLE: begin
                if (fork_req) begin
                    r_d.st   = TFA_SCAN;
                    r_d.idx  = '0;
                    r_d.last = last_lim;
                    r_d.pc   = req_pc;
                    r_d.val  = req_val;
                    r_d.dst  = req_dst;
                    r_d.ksu  = req_ksu;
                    r_d.asid = req_asid;
                end
            end
            TFA_SCAN: begin
                if (elig[r_q.idx]) begin
                    r_d.st    = TFA_IDLE;
                    r_d.wctx  = r_q.idx;
                    r_d.wr    = 1'b1;
                    r_d.dirty = 1'b1;
                    r_d.act   = 1'b1;
                    r_d.done  = 1'b1;
                    r_d.ok    = 1'b1;
                end else if (r_q.idx == r_q.last) begin
                    r_d.st       = TFA_IDLE;
                    r_d.exc_we   = 1'b1;
                    r_d.exc_code = TFA_EXC_NO_FREE;
                    r_d.done     = 1'b1;
                    r_d.fault    = 1'b1;
                end else begin
                    r_d.idx = r_q.idx + 1'b1;
                end
            end
            default: r_d.st = TFA_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign busy     = (r_q.st == TFA_SCAN);
    assign wr_ctx   = r_q.wctx;
    assign wr_stb   = r_q.wr;
    assign pc_data  = r_q.pc;
    assign val_data = r_q.val;
    assign dst_idx  = r_q.dst;
    assign st_dirty = r_q.dirty;
    assign st_act   = r_q.act;
    assign st_ksu   = r_q.ksu;
    assign st_asid  = r_q.asid;
    assign exc_we   = r_q.exc_we;
    assign exc_code = r_q.exc_code;
    assign done     = r_q.done;
    assign ok       = r_q.ok;
    assign fault    = r_q.fault;

    // R9: each completion reports exactly one outcome
    a_r9_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (ok ^ fault));
    // R9: completion is a single-cycle pulse
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R5: writes only accompany a successful completion
    a_r5_write_on_ok: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> (done && ok));
    // R7: fault carries the exception code and no context write
    a_r7_fault_code: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> (exc_we && exc_code == TFA_EXC_NO_FREE && !wr_stb));
    // R6: status write marks context dirty and activated
    a_r6_status_bits: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> (st_dirty && st_act));
    // R8: the scan is finished once done is raised
    a_r8_idle_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    // R4: scan position never passes the captured limit
    a_r4_idx_bound: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (r_q.idx <= r_q.last));
    // R3: scan advances by one context per cycle
    a_r3_step_one: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && rst_n) |-> (r_q.idx == $past(r_q.idx) + 1'b1));
endmodule

// File: rtl/tfa_fork_alloc.sv
module tfa_fork_alloc #(
    parameter int N_CTX  = 8,
    parameter int VPE_W  = 2,
    parameter int ASID_W = 8,
    parameter int DATA_W = 32,
    parameter int REG_W  = 5,
    localparam int IDX_W = (N_CTX > 1) ? $clog2(N_CTX) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   fork_req,
    input  logic [VPE_W-1:0]       req_vpe,
    input  logic [1:0]             req_ksu,
    input  logic [ASID_W-1:0]      req_asid,
    input  logic [DATA_W-1:0]      req_pc,
    input  logic [DATA_W-1:0]      req_val,
    input  logic [REG_W-1:0]       req_dst,
    input  logic [IDX_W-1:0]       cfg_count,
    input  logic [N_CTX*VPE_W-1:0] ctx_vpe,
    input  logic [N_CTX-1:0]       ctx_dyn,
    input  logic [N_CTX-1:0]       ctx_halt,
    input  logic [N_CTX-1:0]       ctx_act,
    output logic                   busy,
    output logic [IDX_W-1:0]       wr_ctx,
    output logic                   pc_we,
    output logic [DATA_W-1:0]      pc_wdata,
    output logic                   gpr_we,
    output logic [REG_W-1:0]       gpr_addr,
    output logic [DATA_W-1:0]      gpr_wdata,
    output logic                   st_we,
    output logic [1:0]             st_run,
    output logic                   st_dly,
    output logic                   st_dirty,
    output logic                   st_act,
    output logic [1:0]             st_ksu,
    output logic [ASID_W-1:0]      st_asid,
    output logic                   exc_we,
    output logic [2:0]             exc_code,
    output logic                   done,
    output logic                   ok,
    output logic                   fault
);
    logic [N_CTX-1:0] elig;
    logic             wr_stb;

    tfa_elig #(.N_CTX(N_CTX), .VPE_W(VPE_W)) u_elig (
        .ctx_vpe (ctx_vpe),
        .ctx_dyn (ctx_dyn),
        .ctx_halt(ctx_halt),
        .ctx_act (ctx_act),
        .req_vpe (req_vpe),
        .elig    (elig)
    );

    tfa_seq #(
        .N_CTX(N_CTX), .IDX_W(IDX_W), .ASID_W(ASID_W),
        .DATA_W(DATA_W), .REG_W(REG_W)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .fork_req (fork_req),
        .req_ksu  (req_ksu),
        .req_asid (req_asid),
        .req_pc   (req_pc),
        .req_val  (req_val),
        .req_dst  (req_dst),
        .cfg_count(cfg_count),
        .elig     (elig),
        .busy     (busy),
        .wr_ctx   (wr_ctx),
        .wr_stb   (wr_stb),
        .pc_data  (pc_wdata),
        .val_data (gpr_wdata),
        .dst_idx  (gpr_addr),
        .st_dirty (st_dirty),
        .st_act   (st_act),
        .st_ksu   (st_ksu),
        .st_asid  (st_asid),
        .exc_we   (exc_we),
        .exc_code (exc_code),
        .done     (done),
        .ok       (ok),
        .fault    (fault)
    );

    // One commit strobe fans out to the three write ports of the bank.
    assign pc_we  = wr_stb;
    assign gpr_we = wr_stb;
    assign st_we  = wr_stb;
    // A freshly forked context starts running, outside any delay slot.
    assign st_run = 2'b00;
    assign st_dly = 1'b0;
endmodule

// File: tb/tfa_fork_alloc_bench.sv
module tfa_fork_alloc_bench;
    localparam int N = 8;
    localparam int NV = 11;

    typedef struct packed {
        logic [2:0]  cnt;
        logic [15:0] vpe;
        logic [7:0]  dyn;
        logic [7:0]  halt;
        logic [7:0]  act;
        logic [1:0]  rvpe;
        logic        eok;
        logic [2:0]  eidx;
    } vec_t;

    localparam vec_t TBL [NV] = '{
        '{3'd7, 16'h0000, 8'hFF, 8'h00, 8'h00, 2'd0, 1'b1, 3'd0},
        '{3'd7, 16'h0000, 8'hFF, 8'h00, 8'h07, 2'd0, 1'b1, 3'd3},
        '{3'd7, 16'h0000, 8'hFF, 8'h1F, 8'h00, 2'd0, 1'b1, 3'd5},
        '{3'd7, 16'h0000, 8'h80, 8'h00, 8'h00, 2'd0, 1'b1, 3'd7},
        '{3'd7, 16'h4555, 8'hFF, 8'h00, 8'h00, 2'd0, 1'b1, 3'd6},
        '{3'd7, 16'h0000, 8'hFF, 8'h00, 8'hFF, 2'd0, 1'b0, 3'd0},
        '{3'd3, 16'h0000, 8'h20, 8'h00, 8'h00, 2'd0, 1'b0, 3'd0},
        '{3'd3, 16'h0000, 8'h08, 8'h00, 8'h00, 2'd0, 1'b1, 3'd3},
        '{3'd0, 16'h0000, 8'hFF, 8'h00, 8'h00, 2'd0, 1'b1, 3'd0},
        '{3'd0, 16'h0000, 8'hFF, 8'h01, 8'h00, 2'd0, 1'b0, 3'd0},
        '{3'd7, 16'h0020, 8'hFF, 8'h00, 8'h00, 2'd2, 1'b1, 3'd2}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fork_req = 1'b0;
    logic [1:0]  req_vpe = '0;
    logic [1:0]  req_ksu = '0;
    logic [7:0]  req_asid = '0;
    logic [31:0] req_pc = '0;
    logic [31:0] req_val = '0;
    logic [4:0]  req_dst = '0;
    logic [2:0]  cfg_count = '0;
    logic [15:0] ctx_vpe = '0;
    logic [7:0]  ctx_dyn = '0;
    logic [7:0]  ctx_halt = '0;
    logic [7:0]  ctx_act = '0;
    logic        busy, pc_we, gpr_we, st_we, st_dly, st_dirty, st_act;
    logic        exc_we, done, ok, fault;
    logic [2:0]  wr_ctx, exc_code;
    logic [31:0] pc_wdata, gpr_wdata;
    logic [4:0]  gpr_addr;
    logic [1:0]  st_run, st_ksu;
    logic [7:0]  st_asid;

    int n_cmp = 0;
    int n_bad = 0;
    int n_cyc = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    tfa_fork_alloc u_tfa_fork_alloc (
        .clk(clk), .rst_n(rst_n), .fork_req(fork_req), .req_vpe(req_vpe),
        .req_ksu(req_ksu), .req_asid(req_asid), .req_pc(req_pc),
        .req_val(req_val), .req_dst(req_dst), .cfg_count(cfg_count),
        .ctx_vpe(ctx_vpe), .ctx_dyn(ctx_dyn), .ctx_halt(ctx_halt),
        .ctx_act(ctx_act), .busy(busy), .wr_ctx(wr_ctx), .pc_we(pc_we),
        .pc_wdata(pc_wdata), .gpr_we(gpr_we), .gpr_addr(gpr_addr),
        .gpr_wdata(gpr_wdata), .st_we(st_we), .st_run(st_run),
        .st_dly(st_dly), .st_dirty(st_dirty), .st_act(st_act),
        .st_ksu(st_ksu), .st_asid(st_asid), .exc_we(exc_we),
        .exc_code(exc_code), .done(done), .ok(ok), .fault(fault)
    );

    task automatic chk(input bit cond, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (!cond) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] idle_word();
        return {56'd0, busy, done, ok, fault, pc_we, gpr_we, st_we, exc_we};
    endfunction

    // Pulse a request, then count edges until done; returns latency (0 = none).
    task automatic fire(output int lat);
        @(negedge clk) fork_req = 1'b1;
        @(negedge clk) fork_req = 1'b0;
        chk(busy == 1'b1, "R8 busy after accept", busy, 1);
        lat = 0;
        for (int c = 1; c <= 12; c++) begin
            @(posedge clk);
            @(negedge clk);
            if (done) begin
                lat = c;
                break;
            end
        end
    endtask

    // Count done pulses over a window, sampled away from the edge.
    task automatic count_done(input int cycles, output int seen);
        seen = 0;
        for (int c = 0; c < cycles; c++) begin
            @(posedge clk);
            @(negedge clk);
            if (done) seen++;
        end
    endtask

    initial begin
        while (!finished) begin
            @(posedge clk);
            n_cyc++;
            if (n_cyc > 100000) begin
                n_bad++;
                $display("FAIL watchdog actual=%0d expected=<100000", n_cyc);
                $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
                $finish;
            end
        end
    end

    initial begin
        int lat, exp_lat, seen;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(idle_word() == 64'd0, "R1 reset outputs", idle_word(), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(idle_word() == 64'd0, "R1 idle after reset", idle_word(), 0);

        // Table walk: R2, R3, R4, R5, R6, R7, R9
        for (int i = 0; i < NV; i++) begin
            cfg_count = TBL[i].cnt;
            ctx_vpe   = TBL[i].vpe;
            ctx_dyn   = TBL[i].dyn;
            ctx_halt  = TBL[i].halt;
            ctx_act   = TBL[i].act;
            req_vpe   = TBL[i].rvpe;
            req_pc    = 32'h1000_0000 + 32'(i * 4);
            req_val   = 32'hA5A5_0000 ^ 32'(i);
            req_dst   = 5'(i + 1);
            req_ksu   = 2'(i % 4);
            req_asid  = 8'(i * 17);
            fire(lat);
            exp_lat = TBL[i].eok ? int'(TBL[i].eidx) + 1 : int'(TBL[i].cnt) + 1;
            chk(lat == exp_lat, "R3 R4 done latency", lat, exp_lat);
            chk(ok == TBL[i].eok && fault == !TBL[i].eok,
                "R9 outcome", {ok, fault}, {TBL[i].eok, !TBL[i].eok});
            if (TBL[i].eok) begin
                chk(wr_ctx == TBL[i].eidx, "R2 R3 selected context", wr_ctx, TBL[i].eidx);
                chk(pc_we && pc_wdata == req_pc, "R5 restart pc write", pc_wdata, req_pc);
                chk(gpr_we && gpr_addr == req_dst && gpr_wdata == req_val,
                    "R5 register write", {gpr_addr, gpr_wdata}, {req_dst, req_val});
                chk(st_we && st_run == 2'b00 && !st_dly && st_dirty && st_act,
                    "R6 status flags", {st_we, st_run, st_dly, st_dirty, st_act}, 6'b100011);
                chk(st_ksu == req_ksu && st_asid == req_asid, "R6 inherited fields",
                    {st_ksu, st_asid}, {req_ksu, req_asid});
                chk(!exc_we, "R5 no exception on success", exc_we, 0);
            end else begin
                chk(exc_we && exc_code == 3'd1, "R7 exception code", {exc_we, exc_code}, 4'b1001);
                chk(!pc_we && !gpr_we && !st_we, "R7 no writes on fault",
                    {pc_we, gpr_we, st_we}, 0);
            end
            @(posedge clk);
            @(negedge clk);
            chk(!done && !ok && !fault, "R9 single pulse", {done, ok, fault}, 0);
        end

        // R8: second request mid-scan is ignored
        cfg_count = 3'd7; ctx_vpe = '0; ctx_dyn = 8'h80; ctx_halt = '0; ctx_act = '0;
        req_vpe = 2'd0; req_pc = 32'h0000_1234;
        @(negedge clk) fork_req = 1'b1;
        @(negedge clk) fork_req = 1'b0;
        @(negedge clk);
        @(negedge clk) begin fork_req = 1'b1; req_pc = 32'hDEAD_0000; end
        @(negedge clk) fork_req = 1'b0;
        lat = 0;
        for (int c = 0; c < 12; c++) begin
            if (done) break;
            @(posedge clk);
            @(negedge clk);
        end
        chk(done && pc_wdata == 32'h0000_1234, "R8 first request kept", pc_wdata, 32'h1234);
        count_done(12, seen);
        chk(seen == 0, "R8 mid-scan request ignored", seen, 0);

        // R8: request held across the completing edge is ignored
        ctx_dyn = 8'h08;
        @(negedge clk) fork_req = 1'b1;
        @(negedge clk) fork_req = 1'b0;
        repeat (3) @(negedge clk);
        fork_req = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk(done && ok, "R8 completion with concurrent request", {done, ok}, 2'b11);
        fork_req = 1'b0;
        count_done(12, seen);
        chk(seen == 0 && !busy, "R8 concurrent request ignored", seen, 0);

        // R1: reset during a scan
        ctx_dyn = 8'h80;
        @(negedge clk) fork_req = 1'b1;
        @(negedge clk) fork_req = 1'b0;
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk);
        chk(idle_word() == 64'd0, "R1 reset mid-scan", idle_word(), 0);
        rst_n = 1'b1;
        count_done(10, seen);
        chk(seen == 0 && !busy, "R1 no activity after reset", seen, 0);

        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule